// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It does this before the branch resolves. A shift register holds the outcomes of the most recent resolved branches. That history is combined with a slice of the fetch address to pick one 2-bit saturating counter from a table. The upper bit of that counter is the guess. A compile-time mode chooses how history and address are combined: a bitwise XOR of the two, or the two placed side by side.

Fetch presents an address on the lookup side and gets back a direction. It also gets back the history value that produced the guess. When the branch resolves, the pipeline sends back three things on the update side: the address, the real outcome, and that saved history value. The block steps the counter that made the guess. It then rebuilds its history register from the saved value with the new outcome shifted in. Because of this, a late or replayed update still lands on the right entry and repairs the history.

Top module: `branch_dir_pred`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the history is zero, so every lookup predicts not taken. A single taken update to an entry makes a later lookup of that entry predict taken.
- R2: The history output `lk_hist` is zero after reset. After an update it equals `{up_hist[HIST_W-2:0], up_taken}`, where 1 means taken, keeping only the last HIST_W outcomes. Without an update it does not change.
- R3: With the default XOR mode (HIST_W=4, PC_SEL_W=4, PC_LSB=2, 16 entries), the entry index is `history ^ pc[5:2]`.
- R4: In concatenation mode the entry index is `{history, pc[PC_LSB +: PC_SEL_W]}`, with the history in the upper bits.
- R5: A taken update raises the selected counter by one, capped at 3. A not-taken update lowers it by one, floored at 0. Counters change only on updates.
- R6: The lookup output is bit 1 of the selected counter, so counter values 2 and 3 predict taken.
- R7: An update writes the entry selected by `up_pc` and the supplied `up_hist`. The current contents of the history register play no part in that choice.
- R8: When a lookup and an update select the same entry in one cycle, the lookup returns the counter value from before the update.
- R9: With HIST_W=2 and a branch whose outcomes repeat 0,0,1, the predictor learns the pattern. History 00 then predicts taken, and histories 01 and 10 predict not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_hist | output | HIST_W | History value used for this lookup |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome (1 = taken) |
| up_hist | input | HIST_W | History snapshot returned from lookup time |

## Verification
The bench pushes counters against both limits. A counter that wrapped instead of saturating would flip its prediction after three steps in one direction. It also sends updates whose snapshot differs from the live history. A design that indexed with the live register would train the wrong entry, and a later lookup would show the stale value. A same-cycle lookup and update on one entry checks for a forwarding path: a design that forwarded the new value would report taken one cycle early. A concatenation-mode instance is trained on a period-three pattern and then probed with an address that collides with a trained entry only under XOR indexing. A mixed-up hash would therefore show up as a taken guess.

// File: rtl/bdp_pkg.sv
package bdp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_RESET = 2'b01;

  typedef enum logic {
    IDX_XOR = 1'b0,
    IDX_CAT = 1'b1
  } idx_mode_e;

  // one saturating step of a direction counter
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == 2'b11) ? cur : ctr_t'(cur + 2'b01);
    else       nxt = (cur == 2'b00) ? cur : ctr_t'(cur - 2'b01);
    return nxt;
  endfunction

  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bdp_index.sv
module bdp_index #(
  parameter int                  PC_W     = 32,
  parameter int                  HIST_W   = 4,
  parameter int                  PC_SEL_W = 4,
  parameter int                  PC_LSB   = 2,
  parameter bdp_pkg::idx_mode_e  MODE     = bdp_pkg::IDX_XOR,
  parameter int                  IDX_W    = 4
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  logic [PC_SEL_W-1:0] pc_slice;
  assign pc_slice = pc[PC_LSB +: PC_SEL_W];

  generate
    if (MODE == bdp_pkg::IDX_CAT) begin : g_cat
      assign idx = {hist, pc_slice};
    end else begin : g_xor
      logic [IDX_W-1:0] h_ext;
      logic [IDX_W-1:0] p_ext;
      always_comb begin
        h_ext = '0;
        p_ext = '0;
        h_ext[HIST_W-1:0]   = hist;
        p_ext[PC_SEL_W-1:0] = pc_slice;
      end
      assign idx = h_ext ^ p_ext;
    end
  endgenerate

endmodule

// File: rtl/bdp_history.sv
module bdp_history #(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [HIST_W-1:0] upd_snap,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] hist_q
);

  logic [HIST_W-1:0] hist_nxt;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_nxt = upd_taken;
    end else begin : g_many
      assign hist_nxt = {upd_snap[HIST_W-2:0], upd_taken};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      hist_q <= '0;
    else if (upd_en) hist_q <= hist_nxt;
  end

endmodule

// File: rtl/bdp_pht.sv
module bdp_pht #(
  parameter int IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_idx,
  output bdp_pkg::ctr_t       rd_ctr,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_taken,
  output bdp_pkg::ctr_t       wr_old,
  output bdp_pkg::ctr_t       wr_new
);

  localparam int ENTRIES = 1 << IDX_W;

  bdp_pkg::ctr_t tbl [ENTRIES];

  // both reads see the array as it was before the edge
  assign rd_ctr = tbl[rd_idx];
  assign wr_old = tbl[wr_idx];
  assign wr_new = bdp_pkg::ctr_step(wr_old, wr_taken);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= bdp_pkg::CTR_RESET;
    end else if (wr_en) begin
      tbl[wr_idx] <= wr_new;
    end
  end

endmodule

// File: rtl/branch_dir_pred.sv
module branch_dir_pred #(
  parameter int                  PC_W     = 32,
  parameter int                  HIST_W   = 4,
  parameter int                  PC_SEL_W = 4,
  parameter int                  PC_LSB   = 2,
  parameter bdp_pkg::idx_mode_e  MODE     = bdp_pkg::IDX_XOR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              up_valid,
  input  logic [PC_W-1:0]   up_pc,
  input  logic              up_taken,
  input  logic [HIST_W-1:0] up_hist
);

  localparam int XOR_W = (HIST_W > PC_SEL_W) ? HIST_W : PC_SEL_W;
  localparam int IDX_W = (MODE == bdp_pkg::IDX_CAT) ? (HIST_W + PC_SEL_W) : XOR_W;

  // named internal events, observed by the bound checker
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] upd_idx;
  bdp_pkg::ctr_t    lk_ctr;
  bdp_pkg::ctr_t    upd_ctr_old;
  bdp_pkg::ctr_t    upd_ctr_new;
  logic [HIST_W-1:0] ghist;

  bdp_history #(.HIST_W(HIST_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en    (up_valid),
    .upd_snap  (up_hist),
    .upd_taken (up_taken),
    .hist_q    (ghist)
  );

  bdp_index #(
    .PC_W(PC_W), .HIST_W(HIST_W), .PC_SEL_W(PC_SEL_W),
    .PC_LSB(PC_LSB), .MODE(MODE), .IDX_W(IDX_W)
  ) u_lk_index (
    .pc   (lk_pc),
    .hist (ghist),
    .idx  (lk_idx)
  );

  bdp_index #(
    .PC_W(PC_W), .HIST_W(HIST_W), .PC_SEL_W(PC_SEL_W),
    .PC_LSB(PC_LSB), .MODE(MODE), .IDX_W(IDX_W)
  ) u_up_index (
    .pc   (up_pc),
    .hist (up_hist),
    .idx  (upd_idx)
  );

  bdp_pht #(.IDX_W(IDX_W)) u_pht (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_idx),
    .rd_ctr   (lk_ctr),
    .wr_en    (up_valid),
    .wr_idx   (upd_idx),
    .wr_taken (up_taken),
    .wr_old   (upd_ctr_old),
    .wr_new   (upd_ctr_new)
  );

  assign lk_taken = bdp_pkg::ctr_dir(lk_ctr);
  assign lk_hist  = ghist;

endmodule

// File: rtl/bdp_checker.sv
module bdp_checker #(
  parameter int HIST_W = 4,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_taken,
  input logic [HIST_W-1:0] up_hist,
  input logic [HIST_W-1:0] lk_hist,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [1:0]        lk_ctr,
  input logic [IDX_W-1:0]  upd_idx,
  input logic [1:0]        upd_ctr_old
);

  logic [HIST_W:0]   joined;
  logic [HIST_W-1:0] exp_hist;
  logic [1:0]        exp_inc;
  logic [1:0]        exp_dec;

  always_comb begin
    joined   = {up_hist, up_taken};
    exp_hist = joined[HIST_W-1:0];
    exp_inc  = (upd_ctr_old == 2'd3) ? 2'd3 : upd_ctr_old + 2'd1;
    exp_dec  = (upd_ctr_old == 2'd0) ? 2'd0 : upd_ctr_old - 2'd1;
  end

  p_hist_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> lk_hist == $past(exp_hist));

  p_hist_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(lk_hist));

  p_ctr_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_taken) |=>
      ((upd_idx != $past(upd_idx)) || (upd_ctr_old == $past(exp_inc))));

  p_ctr_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_taken) |=>
      ((upd_idx != $past(upd_idx)) || (upd_ctr_old == $past(exp_dec))));

  p_ctr_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> ((lk_idx != $past(lk_idx)) || (lk_ctr == $past(lk_ctr))));

  p_old_on_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (upd_idx == lk_idx)) |-> (lk_ctr == upd_ctr_old));

endmodule

bind branch_dir_pred bdp_checker #(.HIST_W(HIST_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .up_valid    (up_valid),
  .up_taken    (up_taken),
  .up_hist     (up_hist),
  .lk_hist     (lk_hist),
  .lk_idx      (lk_idx),
  .lk_ctr      (lk_ctr),
  .upd_idx     (upd_idx),
  .upd_ctr_old (upd_ctr_old)
);

// File: tb/tb_branch_dir_pred.sv
module tb_branch_dir_pred;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  always #4 clk = ~clk;

  // default instance: XOR, 4-bit history
  logic [31:0] lk_pc = '0, up_pc = '0;
  logic        lk_taken, up_valid = 1'b0, up_taken = 1'b0;
  logic [3:0]  lk_hist, up_hist = '0;

  // concatenation instance: 2-bit history, 2 PC bits
  logic [31:0] c_lk_pc = '0, c_up_pc = '0;
  logic        c_lk_taken, c_up_valid = 1'b0, c_up_taken = 1'b0;
  logic [1:0]  c_lk_hist, c_up_hist = '0;

  branch_dir_pred dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_hist(up_hist)
  );

  branch_dir_pred #(.HIST_W(2), .PC_SEL_W(2), .MODE(bdp_pkg::IDX_CAT)) dut_cat (
    .clk(clk), .rst_n(rst_n), .lk_pc(c_lk_pc), .lk_taken(c_lk_taken), .lk_hist(c_lk_hist),
    .up_valid(c_up_valid), .up_pc(c_up_pc), .up_taken(c_up_taken), .up_hist(c_up_hist)
  );

  int ntests = 0, nfail = 0;
  bit done = 0;
  int m_ctr [16];
  int m_hist = 0;
  int c_ctr [16];
  int c_hist = 0;

  // {pc, outcome}
  localparam logic [32:0] VEC [16] = '{
    {32'h0000_0100, 1'b1}, {32'h0000_0104, 1'b1}, {32'h0000_0100, 1'b0},
    {32'h0000_0238, 1'b1}, {32'h0000_0238, 1'b1}, {32'h0000_0238, 1'b1},
    {32'h0000_0100, 1'b1}, {32'h0000_03FC, 1'b0}, {32'h0000_0104, 1'b1},
    {32'h0000_0238, 1'b0}, {32'h0000_0100, 1'b1}, {32'h0000_0120, 1'b1},
    {32'h0000_0120, 1'b1}, {32'h0000_0104, 1'b0}, {32'h0000_0238, 1'b1},
    {32'h0000_0100, 1'b1}
  };

  function automatic int sat(int c, bit t);
    if (t) return (c >= 3) ? 3 : c + 1;
    return (c <= 0) ? 0 : c - 1;
  endfunction

  function automatic int xidx(int pc, int h);
    return h ^ ((pc / 4) % 16);
  endfunction

  function automatic int cidx(int pc, int h);
    return h * 4 + ((pc / 4) % 4);
  endfunction

  task automatic chk(string tag, int act, int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic x_look(int pc, string tag);
    @(negedge clk);
    lk_pc = pc;
    #1;
    chk(tag, int'(lk_taken), int'(m_ctr[xidx(pc, m_hist)] >= 2));
  endtask

  task automatic x_upd(int pc, bit t, int snap);
    int i;
    @(negedge clk);
    up_pc = pc; up_taken = t; up_hist = 4'(snap); up_valid = 1'b1;
    @(posedge clk);
    #1 up_valid = 1'b0;
    i = xidx(pc, snap);
    m_ctr[i] = sat(m_ctr[i], t);
    m_hist = ((snap * 2) + int'(t)) % 16;
  endtask

  task automatic c_look(int pc, string tag);
    @(negedge clk);
    c_lk_pc = pc;
    #1;
    chk(tag, int'(c_lk_taken), int'(c_ctr[cidx(pc, c_hist)] >= 2));
  endtask

  task automatic c_upd(int pc, bit t, int snap);
    int i;
    @(negedge clk);
    c_up_pc = pc; c_up_taken = t; c_up_hist = 2'(snap); c_up_valid = 1'b1;
    @(posedge clk);
    #1 c_up_valid = 1'b0;
    i = cidx(pc, snap);
    c_ctr[i] = sat(c_ctr[i], t);
    c_hist = ((snap * 2) + int'(t)) % 4;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    nfail++;
    ntests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_ctr[i] = 1; c_ctr[i] = 1; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state
    @(negedge clk);
    chk("R2 reset history", int'(lk_hist), 0);
    chk("R2 reset history cat", int'(c_lk_hist), 0);
    x_look(32'h0000_0000, "R1 reset pred");
    x_look(32'h0000_0024, "R1 reset pred");
    x_look(32'h0000_003C, "R1 reset pred");

    // R1: one taken step flips 01 -> 10
    x_upd(32'h44, 1'b1, 0);
    chk("R2 shift", int'(lk_hist), m_hist);
    x_upd(32'h08, 1'b0, 0);             // restore history to zero
    x_look(32'h44, "R1 one step taken");
    chk("R1 direct", int'(lk_taken), 1);

    // R5 upper saturation then walk down
    x_upd(32'h44, 1'b1, 0);
    x_upd(32'h44, 1'b1, 0);
    x_upd(32'h44, 1'b1, 0);             // stays at 3
    x_upd(32'h44, 1'b0, 0);             // 2
    x_upd(32'h0C, 1'b0, 0);
    x_look(32'h44, "R5 sat high");
    chk("R5 sat high direct", int'(lk_taken), 1);
    x_upd(32'h44, 1'b0, 0);             // 1
    x_upd(32'h0C, 1'b0, 0);
    x_look(32'h44, "R6 ctr 1");
    x_upd(32'h44, 1'b0, 0);
    x_upd(32'h44, 1'b0, 0);
    x_upd(32'h44, 1'b0, 0);             // floor 0
    x_upd(32'h44, 1'b1, 0);             // 1
    x_upd(32'h0C, 1'b0, 0);
    x_look(32'h44, "R5 sat low");
    chk("R5 sat low direct", int'(lk_taken), 0);
    x_upd(32'h44, 1'b1, 0);             // 2
    x_upd(32'h0C, 1'b0, 0);
    x_look(32'h44, "R5 rise");

    // R7: snapshot, not live register, picks the entry
    x_upd(32'h50, 1'b1, 4'b1010);
    chk("R2 snapshot restore", int'(lk_hist), 4'b0101);
    x_upd(32'h0C, 1'b0, 4'b0101);       // history now 1010
    x_look(32'h50, "R7 snapshot entry");
    chk("R7 direct", int'(lk_taken), 1);

    // R8: same entry looked up and updated in one cycle
    @(negedge clk);
    lk_pc = 32'h74; up_pc = 32'h74; up_taken = 1'b1; up_hist = lk_hist; up_valid = 1'b1;
    #1;
    chk("R8 old value on clash", int'(lk_taken), 0);
    @(posedge clk);
    #1 up_valid = 1'b0;
    m_ctr[xidx(32'h74, 10)] = sat(m_ctr[xidx(32'h74, 10)], 1'b1);
    m_hist = 5;
    x_upd(32'h0C, 1'b0, 5);             // history back to 1010
    x_look(32'h74, "R8 write landed");
    chk("R8 direct", int'(lk_taken), 1);

    // vector table walk: R3 index, R6 direction, R2 history
    for (int v = 0; v < 16; v++) begin
      x_look(int'(VEC[v][32:1]), "R3 R6 vector lookup");
      x_upd(int'(VEC[v][32:1]), VEC[v][0], m_hist);
      chk("R2 vector history", int'(lk_hist), m_hist);
    end

    // R9: period-three pattern on the concatenation instance
    for (int k = 0; k < 24; k++) begin
      c_upd(32'h100, (k % 3) == 2, c_hist);
    end
    for (int k = 24; k < 30; k++) begin
      bit outc;
      outc = (k % 3) == 2;
      @(negedge clk);
      c_lk_pc = 32'h100;
      #1;
      chk("R9 pattern learned", int'(c_lk_taken), int'(outc));
      chk("R9 history match", int'(c_lk_taken), int'(c_hist == 0));
      c_look(32'h108, "R4 concat index");
      c_upd(32'h100, outc, c_hist);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule